// File: doc/BRIEF.md
# Hibernation Wake-Count Timer

This block is a small always-on timer. Software uses it to switch off the main power domain for a set interval and then switch it back on. Software first writes a wake count through a plain write port in the fast system clock domain. It then raises a hibernate request. The block drives a regulator-enable output low for exactly that many periods of the 32 kHz slow clock, and then drives it high again.

The request is caught on its rising edge in the system domain and turned into a toggle. The toggle crosses into the slow domain through a two-flop synchronizer, and an edge detector there starts exactly one interval per request. A second toggle returns across the boundary when the interval ends, and this clears the busy status. While busy, the block ignores both requests and count writes, so the count held for the slow domain does not change during a transfer.

Only the slow-domain counter and output flop have to stay powered during hibernation. Both resets are synchronous, active-low and applied together at power-on.

Top module: `hib_wake_timer`

## Requirements
- R1: After reset, reg_en_o is 1 and busy_o is 0.
- R2: A 0-to-1 transition of hib_req, seen at a clk_sys edge while busy_o is 0, is accepted. busy_o reads 1 after that edge, and reg_en_o falls on the third clk_slow rising edge after the accepted toggle.
- R3: Once low, reg_en_o stays low for exactly N clk_slow periods, where N is the wake count last written, and then returns to 1.
- R4: A wake count of 0 gives a low interval of exactly one clk_slow period.
- R5: busy_o is 1 whenever reg_en_o is 0. It returns to 0 within three clk_sys edges after reg_en_o rises.
- R6: A hib_req rising edge that arrives while busy_o is 1 is ignored. No second interval follows.
- R7: A count write (cnt_wr_en = 1) while busy_o is 1 is ignored. The next interval uses the count held before.
- R8: Holding hib_req at 1 starts only one interval. Another interval needs hib_req to go back to 0 and rise again.
- R9: The largest count, 2^CNT_W - 1, gives a low interval of exactly that many slow periods.
- R10: A count write and a request in the same idle clk_sys cycle are both accepted, and the interval uses the newly written count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock |
| rst_sys_n | input | 1 | Synchronous active-low reset, system domain |
| clk_slow | input | 1 | 32 kHz always-on clock |
| rst_slow_n | input | 1 | Synchronous active-low power-on reset, slow domain |
| cnt_wr_en | input | 1 | Write strobe for the wake count |
| cnt_wr_data | input | CNT_W | Wake count value, in slow clock periods |
| hib_req | input | 1 | Hibernate request; its rising edge starts one interval |
| busy_o | output | 1 | 1 from acceptance until the end of the interval has crossed back |
| reg_en_o | output | 1 | Regulator enable; 0 during hibernation |

## Verification
The bench builds the block with CNT_W = 4. This makes the full-scale count of 15 and the zero-count clamp short enough to measure as complete intervals. The slow clock runs at 400 ns with its edges offset from the 10 ns system clock, so the synchronizer latency comes out the same on every run. The bench counts low intervals in slow periods and compares them against the count in use. These counts cover the ordinary, zero and maximum values, plus the cases where a request or write arrives while busy, a request is held high, and a write coincides with a request.

// File: rtl/hib_pkg.sv
// Package hib_pkg
// Shared constants and types for the wake-count timer.
// Assumes nothing beyond the standard language.
package hib_pkg;
    // Number of flops in each clock-domain crossing synchronizer
    localparam int SYNC_DEPTH = 2;

    // Level of the regulator-enable output
    typedef enum logic {
        PWR_OFF = 1'b0,
        PWR_ON  = 1'b1
    } pwr_lvl_e;
endpackage

// File: rtl/hib_sync.sv
// Module hib_sync
// Carries a single-bit level into the clock domain of clk through a
// chain of STAGES flops.
// Assumes: d is a level that stays stable far longer than one clk period.
module hib_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the incoming level through the chain of flops
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hib_req_capture.sv
// Module hib_req_capture
// System-domain side: holds the wake count, catches the request's rising
// edge, flips the request toggle and derives busy from the returned toggle.
// Assumes: ack_s is the slow-domain done toggle already synchronized into clk.
module hib_req_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             req,
    input  logic             ack_s,
    output logic [CNT_W-1:0] wake_cnt,
    output logic             req_tgl,
    output logic             busy
);
    logic req_d;
    logic accept;

    assign busy   = req_tgl ^ ack_s;
    assign accept = req & ~req_d & ~busy;

    // Keep the previous request level for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= req;
    end

    // Take a count write only while idle
    always_ff @(posedge clk) begin
        if (!rst_n)              wake_cnt <= '0;
        else if (wr_en && !busy) wake_cnt <= wr_data;
    end

    // Flip the request toggle once per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)      req_tgl <= 1'b0;
        else if (accept) req_tgl <= ~req_tgl;
    end

    assert_busy_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    assert_cnt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wake_cnt));
    assert_single_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
endmodule

// File: rtl/hib_wake_counter.sv
// Module hib_wake_counter
// Slow-domain side: synchronizes the request toggle, detects its edge,
// loads the wake count (clamping 0 to 1), counts down and drives the
// regulator enable. It flips a done toggle when the interval ends.
// Assumes: load_cnt does not change while a request toggle is in flight.
module hib_wake_counter
    import hib_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_tgl,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             reg_en,
    output logic             done_tgl
);
    logic             tgl_s;
    logic             tgl_d;
    logic             start;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] load_eff;
    pwr_lvl_e         lvl_q;

    hib_sync #(.STAGES(SYNC_DEPTH)) u_req_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (req_tgl),
        .q    (tgl_s)
    );

    assign start    = tgl_s ^ tgl_d;
    assign load_eff = (load_cnt == '0) ? CNT_W'(1) : load_cnt;
    assign reg_en   = (lvl_q == PWR_ON);

    // Remember the synchronized toggle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tgl_d <= 1'b0;
        else        tgl_d <= tgl_s;
    end

    // Run the interval: load, count down, release and report done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q    <= PWR_ON;
            cnt_q    <= '0;
            done_tgl <= 1'b0;
        end else if (lvl_q == PWR_ON) begin
            if (start) begin
                lvl_q <= PWR_OFF;
                cnt_q <= load_eff;
            end
        end else if (cnt_q == CNT_W'(1)) begin
            lvl_q    <= PWR_ON;
            cnt_q    <= '0;
            done_tgl <= ~done_tgl;
        end else begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assert_start_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !reg_en);
    assert_start_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> reg_en);
    assert_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> (cnt_q != '0));
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en && cnt_q > CNT_W'(1)) |=> (!reg_en && cnt_q == $past(cnt_q) - CNT_W'(1)));
    assert_release_at_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_en) |-> ($past(cnt_q) == CNT_W'(1)));
endmodule

// File: rtl/hib_wake_timer.sv
// Module hib_wake_timer (top)
// Hibernation wake-count timer: a system-domain capture stage and an
// always-on slow-domain counter, joined by a toggle handshake.
// Assumes: rst_sys_n and rst_slow_n are applied together at power-on.
module hib_wake_timer
    import hib_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_sys,
    input  logic             rst_sys_n,
    input  logic             clk_slow,
    input  logic             rst_slow_n,
    input  logic             cnt_wr_en,
    input  logic [CNT_W-1:0] cnt_wr_data,
    input  logic             hib_req,
    output logic             busy_o,
    output logic             reg_en_o
);
    logic [CNT_W-1:0] wake_cnt;
    logic             req_tgl;
    logic             done_tgl;
    logic             done_s;

    hib_req_capture #(.CNT_W(CNT_W)) u_capture (
        .clk     (clk_sys),
        .rst_n   (rst_sys_n),
        .wr_en   (cnt_wr_en),
        .wr_data (cnt_wr_data),
        .req     (hib_req),
        .ack_s   (done_s),
        .wake_cnt(wake_cnt),
        .req_tgl (req_tgl),
        .busy    (busy_o)
    );

    hib_sync #(.STAGES(SYNC_DEPTH)) u_done_sync (
        .clk  (clk_sys),
        .rst_n(rst_sys_n),
        .d    (done_tgl),
        .q    (done_s)
    );

    hib_wake_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk_slow),
        .rst_n   (rst_slow_n),
        .req_tgl (req_tgl),
        .load_cnt(wake_cnt),
        .reg_en  (reg_en_o),
        .done_tgl(done_tgl)
    );

    assert_busy_covers_low_R5: assert property (@(posedge clk_slow)
        disable iff (!rst_slow_n || !rst_sys_n)
        !reg_en_o |-> busy_o);
endmodule

// File: tb/sim_hib_wake_timer.sv
module sim_hib_wake_timer;
    localparam int CNT_W = 4;

    logic clk_sys = 1'b0;
    logic clk_slow = 1'b0;
    logic rst_sys_n = 1'b0;
    logic rst_slow_n = 1'b0;
    logic cnt_wr_en = 1'b0;
    logic [CNT_W-1:0] cnt_wr_data = '0;
    logic hib_req = 1'b0;
    logic busy_o;
    logic reg_en_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk_sys = ~clk_sys;
    initial begin
        #3;
        forever #200 clk_slow = ~clk_slow;
    end

    hib_wake_timer #(.CNT_W(CNT_W)) u0 (
        .clk_sys(clk_sys), .rst_sys_n(rst_sys_n),
        .clk_slow(clk_slow), .rst_slow_n(rst_slow_n),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data),
        .hib_req(hib_req), .busy_o(busy_o), .reg_en_o(reg_en_o)
    );

    // Table entries: {count written [7:4], expected low periods [3:0]}
    localparam int NVEC = 6;
    localparam logic [7:0] VEC [NVEC] = '{8'h33, 8'h11, 8'h01, 8'h77, 8'hFF, 8'h22};

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cnt(input int v);
        @(negedge clk_sys);
        cnt_wr_en = 1'b1; cnt_wr_data = CNT_W'(v);
        @(negedge clk_sys);
        cnt_wr_en = 1'b0;
    endtask

    // Pulse the request for one sys cycle; busy must show right after
    task automatic pulse_req(input string tag);
        @(negedge clk_sys);
        hib_req = 1'b1;
        @(negedge clk_sys);
        hib_req = 1'b0;
        check(tag, int'(busy_o), 1);
    endtask

    // Wait for the output to drop; returns 1 if it did
    task automatic wait_fall(output bit fell);
        fell = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk_sys);
            if (!reg_en_o) begin fell = 1'b1; break; end
        end
    endtask

    // Count slow periods the output stays low; also track busy while low
    task automatic measure_low(output int n, output int busy_bad);
        n = 0; busy_bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk_slow);
            if (reg_en_o) break;
            n++;
            if (!busy_o) busy_bad++;
        end
    endtask

    // Check busy clears within three sys cycles after the output rises
    task automatic check_busy_clear(input string tag);
        int k;
        k = 0;
        while (busy_o && k < 10) begin @(negedge clk_sys); k++; end
        check(tag, int'(k <= 3), 1);
    endtask

    // Output must stay high and busy low for a number of slow periods
    task automatic check_quiet(input string tag, input int periods);
        int low_seen;
        low_seen = 0;
        for (int i = 0; i < periods; i++) begin
            @(negedge clk_slow);
            if (!reg_en_o || busy_o) low_seen++;
        end
        check(tag, low_seen, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_sys);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bit fell;
        int n, bb;

        repeat (4) @(negedge clk_slow);
        check("R1 reg_en after reset", int'(reg_en_o), 1);
        check("R1 busy after reset", int'(busy_o), 0);
        @(negedge clk_sys);
        rst_sys_n = 1'b1; rst_slow_n = 1'b1;
        repeat (3) @(negedge clk_sys);
        check("R1 reg_en after release", int'(reg_en_o), 1);

        // Table walk: R3 ordinary counts, R4 zero clamp, R9 full scale
        for (int v = 0; v < NVEC; v++) begin
            write_cnt(int'(VEC[v][7:4]));
            pulse_req("R2 busy on accept");
            wait_fall(fell);
            check("R2 output falls", int'(fell), 1);
            measure_low(n, bb);
            check("R3 R4 R9 low periods", n, int'(VEC[v][3:0]));
            check("R5 busy while low", bb, 0);
            check_busy_clear("R5 busy clears");
        end

        // R6: request while busy is ignored
        write_cnt(5);
        pulse_req("R2 busy on accept");
        wait_fall(fell);
        pulse_req("R6 busy stays during ignored req");
        measure_low(n, bb);
        check("R6 interval length", n, 5);
        check_busy_clear("R5 busy clears");
        check_quiet("R6 no second interval", 8);

        // R7: write while busy is ignored
        write_cnt(4);
        pulse_req("R2 busy on accept");
        wait_fall(fell);
        write_cnt(9);
        measure_low(n, bb);
        check("R7 interval length", n, 4);
        check_busy_clear("R5 busy clears");
        pulse_req("R2 busy on accept");
        wait_fall(fell);
        measure_low(n, bb);
        check("R7 held count reused", n, 4);
        check_busy_clear("R5 busy clears");

        // R8: held request starts a single interval
        write_cnt(2);
        @(negedge clk_sys);
        hib_req = 1'b1;
        wait_fall(fell);
        measure_low(n, bb);
        check("R8 first interval", n, 2);
        check_busy_clear("R5 busy clears");
        check_quiet("R8 no repeat while held", 8);
        @(negedge clk_sys);
        hib_req = 1'b0;

        // R10: write and request in the same cycle
        @(negedge clk_sys);
        cnt_wr_en = 1'b1; cnt_wr_data = CNT_W'(6); hib_req = 1'b1;
        @(negedge clk_sys);
        cnt_wr_en = 1'b0; hib_req = 1'b0;
        check("R10 busy on accept", int'(busy_o), 1);
        wait_fall(fell);
        measure_low(n, bb);
        check("R10 new count used", n, 6);
        check_busy_clear("R5 busy clears");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule